// File: doc/BRIEF.md
# Dual-Channel Serial DAC Command Register

This block is the digital front end of a two-channel voltage DAC. A host writes it over a three-wire serial link made of an active-low select, a serial clock and a data line. The block samples all three lines in a faster system clock domain and assembles a 16-bit command word. When the select line is released, the word is applied. Its upper byte is a set of independent control flags and its lower byte is an 8-bit code.

Each control flag has a single job. Two flags choose which channel code registers take the data byte. Two other flags put a channel to sleep. The remaining four flags are spare. For each channel the block outputs the effective code, which the analog ladder downstream would convert. A sleeping channel outputs zero but keeps its stored code, and that code returns when the channel wakes. A frame applies only if at least 16 clock edges arrived while the select line was low.

Top module: `dual_dac_cmd_front`

## Requirements
- R1: The command word is 16 bits and its first received bit is word bit 15. Bit 8 loads channel A, bit 9 loads channel B, bit 11 puts channel A to sleep, bit 12 puts channel B to sleep, and bits 7..0 are the code with bit 7 received first.
- R2: A bit is taken only on a rising serial-clock edge while the select is low. Edges seen with the select high are neither shifted nor counted.
- R3: The two load flags are independent. A set flag copies the code into that channel's register, so with both set both channels receive the same code. With neither set, no register changes.
- R4: Every applied command overwrites both sleep flags. A cleared flag wakes its channel.
- R5: Registers and outputs change only after a select rising edge. They never change while bits are being shifted, even after a full word has arrived.
- R6: A sleeping channel drives an effective code of zero and raises its sleep output. The stored code is kept and appears again once the channel wakes.
- R7: One frame may be sent in several pieces with pauses between them, as long as the select stays low throughout.
- R8: Word bits 15, 14, 13 and 10 have no effect on any output.
- R9: A frame with fewer than 16 counted edges is discarded when the select rises.
- R10: A frame with more than 16 counted edges applies its last 16 bits.
- R11: The select rise passes a two-stage synchronizer. Outputs show the new command after the third system clock rising edge that samples the select high.
- R12: A synchronous reset clears both code registers and both sleep flags. Both outputs then read zero and neither channel reads as sleeping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Frame select, active low |
| sclk | input | 1 | Serial bit clock; data is taken on its rising edge |
| sdi | input | 1 | Serial data, first bit is the word MSB |
| out_code_a | output | 8 | Effective code for channel A (zero while asleep) |
| out_code_b | output | 8 | Effective code for channel B (zero while asleep) |
| off_a | output | 1 | Channel A is asleep |
| off_b | output | 1 | Channel B is asleep |

## Verification
A fault in the bit counter or in the shift register shows at the ports only at the next select rise. The visible symptoms are a discarded frame, the wrong channel being loaded, or a code taken from a shifted bit window. Each of these appears three clock edges after the rise. A fault in a stored code stays hidden while its channel sleeps and shows on the first clock after the wake-up command takes effect. The sleep gating, by contrast, shows on the same clock as the flag changes. The bench compares all four outputs on every clock against a model built on a bit queue, so a fault is reported on the first cycle in which it reaches a port.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;

   // control byte layout (word bits above the code): behaviour depends on it
   localparam int CTRL_W  = 8;
   localparam int NCH     = 2;
   localparam int LD_BASE = 0;   // load flag of channel c at ctrl bit LD_BASE+c
   localparam int SD_BASE = 3;   // sleep flag of channel c at ctrl bit SD_BASE+c

   function automatic int ld_pos(input int code_w, input int ch);
      return code_w + LD_BASE + ch;
   endfunction

   function automatic int sd_pos(input int code_w, input int ch);
      return code_w + SD_BASE + ch;
   endfunction

endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
   parameter int             W      = 1,
   parameter int             STAGES = 2,
   parameter logic [W-1:0]   INIT   = '0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [STAGES-1:0][W-1:0] pipe;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("dacfe_sync needs at least two stages");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) pipe <= {STAGES{INIT}};
      else     pipe <= {pipe[STAGES-2:0], d};
   end

   assign q = pipe[STAGES-1];

endmodule

// File: rtl/dacfe_shifter.sv
module dacfe_shifter #(
   parameter int FRAME = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cs_s,
   input  logic             sclk_s,
   input  logic             sdi_s,
   output logic             exec,
   output logic [FRAME-1:0] word
);

   localparam int CW = $clog2(FRAME + 1);

   logic          sclk_d;
   logic          cs_d;
   logic [CW-1:0] cnt;
   logic [FRAME-1:0] sr;
   logic          sclk_rise;
   logic          cs_rise;

   assign sclk_rise = sclk_s & ~sclk_d;
   assign cs_rise   = cs_s & ~cs_d;

   always_ff @(posedge clk) begin
      if (rst) begin
         sclk_d <= 1'b0;
         cs_d   <= 1'b1;
         cnt    <= '0;
         sr     <= '0;
      end else begin
         sclk_d <= sclk_s;
         cs_d   <= cs_s;
         if (cs_s) begin
            cnt <= '0;
         end else if (sclk_rise) begin
            sr <= {sr[FRAME-2:0], sdi_s};
            if (cnt != CW'(FRAME)) cnt <= cnt + 1'b1;
         end
      end
   end

   assign exec = cs_rise && (cnt == CW'(FRAME));
   assign word = sr;

   p_count_cap_r10 : assert property (@(posedge clk) disable iff (rst)
      cnt <= CW'(FRAME));

   p_idle_clears_r2 : assert property (@(posedge clk) disable iff (rst)
      (cs_s && sclk_rise) |=> (cnt == '0 && $stable(sr)));

endmodule

// File: rtl/dacfe_chan.sv
module dacfe_chan #(
   parameter int CODE_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              exec,
   input  logic              ld,
   input  logic              sd,
   input  logic [CODE_W-1:0] data,
   output logic [CODE_W-1:0] eff,
   output logic              asleep
);

   logic [CODE_W-1:0] code_q;
   logic              sd_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         code_q <= '0;
         sd_q   <= 1'b0;
      end else if (exec) begin
         if (ld) code_q <= data;
         sd_q <= sd;
      end
   end

   assign eff    = sd_q ? '0 : code_q;
   assign asleep = sd_q;

   p_code_hold_r3 : assert property (@(posedge clk) disable iff (rst)
      !(exec && ld) |=> $stable(code_q));

endmodule

// File: rtl/dual_dac_cmd_front.sv
module dual_dac_cmd_front #(
   parameter int CODE_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cs_n,
   input  logic              sclk,
   input  logic              sdi,
   output logic [CODE_W-1:0] out_code_a,
   output logic [CODE_W-1:0] out_code_b,
   output logic              off_a,
   output logic              off_b
);
   import dacfe_pkg::*;

   localparam int FRAME = CTRL_W + CODE_W;

   generate
      if (CODE_W < 1 || CODE_W > 16) begin : g_bad_code_w
         $error("CODE_W out of supported range");
      end
   endgenerate

   logic [2:0]       raw;
   logic [2:0]       synced;
   logic             exec;
   logic [FRAME-1:0] word;
   logic [CODE_W-1:0] eff [NCH];
   logic [NCH-1:0]    slp;

   assign raw = {cs_n, sclk, sdi};

   dacfe_sync #(.W(3), .STAGES(SYNC_STAGES), .INIT(3'b100)) i_sync (
      .clk (clk),
      .rst (rst),
      .d   (raw),
      .q   (synced)
   );

   dacfe_shifter #(.FRAME(FRAME)) i_shift (
      .clk    (clk),
      .rst    (rst),
      .cs_s   (synced[2]),
      .sclk_s (synced[1]),
      .sdi_s  (synced[0]),
      .exec   (exec),
      .word   (word)
   );

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_ch
         dacfe_chan #(.CODE_W(CODE_W)) i_chan (
            .clk    (clk),
            .rst    (rst),
            .exec   (exec),
            .ld     (word[ld_pos(CODE_W, c)]),
            .sd     (word[sd_pos(CODE_W, c)]),
            .data   (word[CODE_W-1:0]),
            .eff    (eff[c]),
            .asleep (slp[c])
         );
      end
   endgenerate

   assign out_code_a = eff[0];
   assign out_code_b = eff[1];
   assign off_a      = slp[0];
   assign off_b      = slp[1];

   p_zero_when_off_r6 : assert property (@(posedge clk) disable iff (rst)
      (off_a |-> out_code_a == '0) and (off_b |-> out_code_b == '0));

   p_update_at_cs_r5 : assert property (@(posedge clk) disable iff (rst)
      !($stable(out_code_a) && $stable(out_code_b) && $stable(off_a) && $stable(off_b))
      |-> $past(exec));

endmodule

// File: tb/test_dual_dac_cmd_front.sv
module test_dual_dac_cmd_front;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       cs_n = 1'b1;
   logic       sclk = 1'b0;
   logic       sdi = 1'b0;
   logic [7:0] out_code_a, out_code_b;
   logic       off_a, off_b;

   int checks = 0;
   int errors = 0;

   // behavioural model
   bit         q[$];
   logic [7:0] m_code [2];
   logic       m_sd   [2];
   logic [7:0] n_code [2];
   logic       n_sd   [2];
   int         delay = 0;
   bit         track = 0;

   always #4 clk = ~clk;

   dual_dac_cmd_front i_dual_dac_cmd_front (
      .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
      .out_code_a(out_code_a), .out_code_b(out_code_b),
      .off_a(off_a), .off_b(off_b)
   );

   function automatic logic [7:0] eff_of(input int c);
      return m_sd[c] ? 8'h00 : m_code[c];
   endfunction

   // per-cycle comparison: R5 R11 (update timing) against the model
   always @(posedge clk) begin
      #2;
      if (track) begin
         if (delay > 0) begin
            delay--;
            if (delay == 0) begin
               for (int c = 0; c < 2; c++) begin
                  m_code[c] = n_code[c];
                  m_sd[c]   = n_sd[c];
               end
            end
         end
         checks++;
         if (out_code_a !== eff_of(0) || out_code_b !== eff_of(1) ||
             off_a !== m_sd[0] || off_b !== m_sd[1]) begin
            errors++;
            $display("FAIL R5 R11 per-cycle: got a=%h b=%h offa=%b offb=%b exp a=%h b=%h offa=%b offb=%b",
                     out_code_a, out_code_b, off_a, off_b,
                     eff_of(0), eff_of(1), m_sd[0], m_sd[1]);
         end
      end
   end

   task automatic model_exec();
      logic [15:0] w;
      if (q.size() >= 16) begin
         for (int i = 0; i < 16; i++) w[15-i] = q[q.size()-16+i];
         for (int c = 0; c < 2; c++) begin
            n_code[c] = w[8+c] ? w[7:0] : m_code[c];
            n_sd[c]   = w[11+c];
         end
         delay = 3;
      end
   endtask

   task automatic cs_low();
      @(negedge clk) cs_n = 1'b0;
      q.delete();
      repeat (2) @(negedge clk);
   endtask

   task automatic cs_high();
      @(negedge clk) cs_n = 1'b1;
      model_exec();
      repeat (8) @(negedge clk);
   endtask

   task automatic put_bit(input logic b);
      @(negedge clk) sdi = b;
      if (cs_n == 1'b0) q.push_back(b);
      repeat (2) @(negedge clk);
      sclk = 1'b1;
      repeat (2) @(negedge clk);
      sclk = 1'b0;
   endtask

   task automatic put_bits(input logic [15:0] v, input int n);
      for (int i = n - 1; i >= 0; i--) put_bit(v[i]);
   endtask

   task automatic send(input logic [7:0] ctrl, input logic [7:0] data);
      cs_low();
      put_bits({ctrl, data}, 16);
      cs_high();
   endtask

   task automatic expect_state(input string tag, input logic [7:0] a, input logic [7:0] b,
                               input logic oa, input logic ob);
      checks++;
      if (out_code_a !== a || out_code_b !== b || off_a !== oa || off_b !== ob) begin
         errors++;
         $display("FAIL %s: got a=%h b=%h offa=%b offb=%b exp a=%h b=%h offa=%b offb=%b",
                  tag, out_code_a, out_code_b, off_a, off_b, a, b, oa, ob);
      end
   endtask

   initial begin
      for (int c = 0; c < 2; c++) begin
         m_code[c] = '0; m_sd[c] = 1'b0; n_code[c] = '0; n_sd[c] = 1'b0;
      end
      repeat (4) @(negedge clk);
      rst = 1'b0;
      track = 1;
      expect_state("R12 reset state", 8'h00, 8'h00, 1'b0, 1'b0);

      // R1 R3: load both channels from one byte
      send(8'b0000_0011, 8'h80);
      expect_state("R1 R3 load both", 8'h80, 8'h80, 1'b0, 1'b0);

      // R3: load A only
      send(8'b0000_0001, 8'h3C);
      expect_state("R3 load A only", 8'h3C, 8'h80, 1'b0, 1'b0);

      // R8: load B only with every spare bit set
      send(8'b1110_0110, 8'hC5);
      expect_state("R8 spare bits inert", 8'h3C, 8'hC5, 1'b0, 1'b0);

      // R4 R6: no load, sleep A
      send(8'b0000_1000, 8'hFF);
      expect_state("R4 R6 sleep A", 8'h00, 8'hC5, 1'b1, 1'b0);

      // R6: sleep both while loading A
      send(8'b0001_1001, 8'h11);
      expect_state("R6 sleep both", 8'h00, 8'h00, 1'b1, 1'b1);

      // R4 R6: wake all, stored codes return
      send(8'b0000_0000, 8'hAA);
      expect_state("R6 wake restores", 8'h11, 8'hC5, 1'b0, 1'b0);

      // R7: frame split in two pieces with a pause
      cs_low();
      put_bits({8'h00, 8'b0000_0010}, 8);
      repeat (20) @(negedge clk);
      expect_state("R5 mid-frame hold", 8'h11, 8'hC5, 1'b0, 1'b0);
      put_bits({8'h00, 8'h5A}, 8);
      cs_high();
      expect_state("R7 segmented", 8'h11, 8'h5A, 1'b0, 1'b0);

      // R9 R2: short frame, edges while deselected, short frame again
      cs_low();
      put_bits({6'b0, 10'b11_0101_0101}, 10);
      cs_high();
      expect_state("R9 short discarded", 8'h11, 8'h5A, 1'b0, 1'b0);
      put_bits(16'hFFFF, 8);
      cs_low();
      put_bits({8'h00, 8'h03}, 8);
      cs_high();
      expect_state("R2 deselected edges not counted", 8'h11, 8'h5A, 1'b0, 1'b0);

      // R10: 20 bits, last 16 apply
      cs_low();
      put_bits(16'h000F, 4);
      put_bits({8'b0000_0001, 8'h77}, 16);
      cs_high();
      expect_state("R10 long frame", 8'h77, 8'h5A, 1'b0, 1'b0);

      // R5: full word in, select still low
      cs_low();
      put_bits({8'b0000_0011, 8'h00}, 16);
      repeat (10) @(negedge clk);
      expect_state("R5 no update before select rise", 8'h77, 8'h5A, 1'b0, 1'b0);
      cs_high();
      expect_state("R11 applied after select rise", 8'h00, 8'h00, 1'b0, 1'b0);

      // R12: reset mid-run
      send(8'b0000_1011, 8'h9E);
      expect_state("R6 sleep A with load", 8'h00, 8'h9E, 1'b1, 1'b0);
      @(negedge clk);
      rst = 1'b1;
      for (int c = 0; c < 2; c++) begin m_code[c] = '0; m_sd[c] = 1'b0; end
      delay = 0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      repeat (2) @(negedge clk);
      expect_state("R12 reset clears", 8'h00, 8'h00, 1'b0, 1'b0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 8);
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule